// File: doc/BRIEF.md
# Paired-Page Fully Associative Translation Buffer

This block is a fully associative address translation buffer. It has a parameterised number of entries, 16 by default. Each entry holds one tag for an aligned pair of virtual pages. Every pair has an even half and an odd half, and each half maps to its own physical frame. A per-entry size mask lets one entry cover pages from 4 KB up to 256 MB. A global flag makes an entry match whatever the current address-space identifier is.

A lookup presents a virtual address, the current identifier and an access kind. One clock later the block returns a physical address, a cache attribute and a fault code. The fault code reports a miss, an invalid half, a read-inhibit or execute-inhibit violation, or a store to a clean page.

Software-side maintenance uses three side ports:
- An indexed write port, which also flags when the new tag overlaps another live entry.
- An indexed read port.
- A probe port, which returns the lowest index that matches a given tag.

Top module: `pair_tlb`

## Requirements
- R1: While reset is asserted and right after it, `res_valid` and `wr_conflict` are 0. Every entry reads back as all zeros.
- R2: When `wr_en` is high at a clock edge, entry `wr_idx` takes the written tag, identifier, global flag, mask and both half words. From the next cycle the read port at that index returns exactly those values.
- R3: `res_valid` is high in the cycle after a cycle with `lk_valid` high, and low otherwise. Result fields hold their last value while no lookup is presented. A lookup in the same cycle as a write sees the contents from before that write.
- R4: An entry matches when the address tag bits (address bits [31:13]) equal the stored tag on every bit not covered by the mask. It must also either have its global flag set or have a stored identifier equal to `lk_asid`.
- R5: With no fault, two fields come from the selected half:
  - The physical address is the half's frame number shifted left by 12, with address bits [11+m:0] copied from the virtual address. Here m is the number of mask bits, and the mask must be contiguous ones from bit 0.
  - `res_cattr` is the half's attribute field.
  - The half is chosen by virtual address bit 12+m: 0 selects the first half word, 1 the second.
  - On any fault, `res_pa` and `res_cattr` are 0.
- R6: No matching entry gives fault code 1 (miss).
- R7: A match whose selected half has its valid bit (bit 0 of the half word) clear gives fault code 2.
- R8: A load (access code 0 or 3) to a half with bit 26 set gives fault code 3. A fetch (access code 2) to a half with bit 25 set gives fault code 4. Half word layout: bit 0 valid, bit 1 dirty, bits 4:2 attribute, bits 24:5 frame number, bit 25 execute-inhibit, bit 26 read-inhibit.
- R9: A store (access code 1) to a valid half with its dirty bit (bit 1) clear gives fault code 5. A store is never reported as an inhibit fault.
- R10: Fault priority is miss, then invalid, then inhibit, then modified.
- R11: When several entries match a lookup, the lowest index is used and no fault is raised for the overlap.
- R12: `pr_found` is 1 when some entry matches `pr_vpn2` and `pr_asid` under the R4 rule. `pr_idx` is then the lowest such index, and it is 0 when nothing matches.
- R13: `wr_conflict` is 1 in the cycle after a write exactly when the written tag overlaps another entry (not `wr_idx`) that has at least one valid half. Overlap is judged on the tag bits outside both masks, with identifiers equal or either global flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_pa | output | 32 | Physical address (0 on fault) |
| res_cattr | output | 3 | Cache attribute (0 on fault) |
| res_fault | output | 3 | Fault code, 0 for none |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn2 | input | 19 | Pair tag to write |
| wr_asid | input | 8 | Identifier to write |
| wr_global | input | 1 | Global flag to write |
| wr_mask | input | 16 | Size mask to write |
| wr_lo0 | input | 27 | Even half word |
| wr_lo1 | input | 27 | Odd half word |
| wr_conflict | output | 1 | Overlap found by the previous write |
| rd_idx | input | 4 | Entry index to read |
| rd_vpn2 | output | 19 | Stored tag |
| rd_asid | output | 8 | Stored identifier |
| rd_global | output | 1 | Stored global flag |
| rd_mask | output | 16 | Stored size mask |
| rd_lo0 | output | 27 | Stored even half |
| rd_lo1 | output | 27 | Stored odd half |
| pr_vpn2 | input | 19 | Probe tag |
| pr_asid | input | 8 | Probe identifier |
| pr_found | output | 1 | Probe hit |
| pr_idx | output | 4 | Lowest matching index |

## Verification
A corrupted entry field can only show up through the ports. It appears at the read port in the same cycle it is selected. For lookups, it surfaces one cycle after the next lookup that selects that entry, as a wrong frame, a wrong half or a wrong fault code. A wrong priority or a wrong half select shows on the first access whose half has several flag bits set at once. A bad mask or tag compare shows as a miss, or as a lowest-index choice on the probe and lookup ports. A bench model that tracks every entry and compares all outputs on every clock catches such a fault in the first exposing cycle.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int PG_OFS_W = 12;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'd0,
    ACC_STORE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_LOAD_ALT = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_MISS     = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_RD_INH   = 3'd3,
    FLT_EX_INH   = 3'd4,
    FLT_MODIFIED = 3'd5
  } fault_e;
endpackage

// File: rtl/ptlb_cmp.sv
module ptlb_cmp #(
  parameter int VPN2_W = 19,
  parameter int ASID_W = 8,
  parameter int MASK_W = 16
) (
  input  logic [VPN2_W-1:0] tag_vpn2,
  input  logic [ASID_W-1:0] tag_asid,
  input  logic              tag_global,
  input  logic [MASK_W-1:0] tag_mask,
  input  logic [VPN2_W-1:0] key_vpn2,
  input  logic [ASID_W-1:0] key_asid,
  input  logic              key_global,
  input  logic [MASK_W-1:0] key_mask,
  output logic              hit
);
  logic [VPN2_W-1:0] care;
  logic [VPN2_W-1:0] diff;

  always_comb begin
    care               = '1;
    care[MASK_W-1:0]   = ~(tag_mask | key_mask);
    diff               = (tag_vpn2 ^ key_vpn2) & care;
    hit                = (diff == '0) &&
                         (tag_global || key_global || (tag_asid == key_asid));
  end
endmodule

// File: rtl/ptlb_first.sv
module ptlb_first #(
  parameter  int IDX_W = 4,
  localparam int N     = 1 << IDX_W
) (
  input  logic [N-1:0]     hits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx   = '0;
    found = |hits;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ptlb_store.sv
module ptlb_store #(
  parameter  int IDX_W  = 4,
  parameter  int VPN2_W = 19,
  parameter  int ASID_W = 8,
  parameter  int MASK_W = 16,
  parameter  int LO_W   = 27,
  localparam int N      = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  output logic [VPN2_W-1:0] e_vpn2   [N],
  output logic [ASID_W-1:0] e_asid   [N],
  output logic              e_global [N],
  output logic [MASK_W-1:0] e_mask   [N],
  output logic [LO_W-1:0]   e_lo0    [N],
  output logic [LO_W-1:0]   e_lo1    [N]
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic load_en;

    always_comb load_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vpn2[g]   <= '0;
        e_asid[g]   <= '0;
        e_global[g] <= 1'b0;
        e_mask[g]   <= '0;
        e_lo0[g]    <= '0;
        e_lo1[g]    <= '0;
      end else if (load_en) begin
        e_vpn2[g]   <= wr_vpn2;
        e_asid[g]   <= wr_asid;
        e_global[g] <= wr_global;
        e_mask[g]   <= wr_mask;
        e_lo0[g]    <= wr_lo0;
        e_lo1[g]    <= wr_lo1;
      end
    end
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import ptlb_pkg::*;
#(
  parameter  int IDX_W  = 4,
  parameter  int VA_W   = 32,
  parameter  int PA_W   = 32,
  parameter  int ASID_W = 8,
  parameter  int MASK_W = 16,
  localparam int VPN2_W = VA_W - PG_OFS_W - 1,
  localparam int PFN_W  = PA_W - PG_OFS_W,
  localparam int LO_W   = PFN_W + 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  output logic              res_valid,
  output logic [PA_W-1:0]   res_pa,
  output logic [2:0]        res_cattr,
  output logic [2:0]        res_fault,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  output logic              wr_conflict,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [VPN2_W-1:0] rd_vpn2,
  output logic [ASID_W-1:0] rd_asid,
  output logic              rd_global,
  output logic [MASK_W-1:0] rd_mask,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  input  logic [VPN2_W-1:0] pr_vpn2,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_found,
  output logic [IDX_W-1:0]  pr_idx
);
  localparam int N       = 1 << IDX_W;
  localparam int SEL_W   = MASK_W + 1;
  localparam int OFS_MAX = MASK_W + PG_OFS_W;

  logic [VPN2_W-1:0] e_vpn2   [N];
  logic [ASID_W-1:0] e_asid   [N];
  logic              e_global [N];
  logic [MASK_W-1:0] e_mask   [N];
  logic [LO_W-1:0]   e_lo0    [N];
  logic [LO_W-1:0]   e_lo1    [N];

  ptlb_store #(
    .IDX_W(IDX_W), .VPN2_W(VPN2_W), .ASID_W(ASID_W), .MASK_W(MASK_W), .LO_W(LO_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn2(wr_vpn2), .wr_asid(wr_asid), .wr_global(wr_global), .wr_mask(wr_mask),
    .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .e_vpn2(e_vpn2), .e_asid(e_asid), .e_global(e_global), .e_mask(e_mask),
    .e_lo0(e_lo0), .e_lo1(e_lo1)
  );

  logic [N-1:0] lk_hits, pr_hits, cf_raw, cf_hits;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    ptlb_cmp #(.VPN2_W(VPN2_W), .ASID_W(ASID_W), .MASK_W(MASK_W)) u_lk (
      .tag_vpn2(e_vpn2[g]), .tag_asid(e_asid[g]), .tag_global(e_global[g]), .tag_mask(e_mask[g]),
      .key_vpn2(lk_va[VA_W-1:PG_OFS_W+1]), .key_asid(lk_asid), .key_global(1'b0),
      .key_mask('0), .hit(lk_hits[g])
    );
    ptlb_cmp #(.VPN2_W(VPN2_W), .ASID_W(ASID_W), .MASK_W(MASK_W)) u_pr (
      .tag_vpn2(e_vpn2[g]), .tag_asid(e_asid[g]), .tag_global(e_global[g]), .tag_mask(e_mask[g]),
      .key_vpn2(pr_vpn2), .key_asid(pr_asid), .key_global(1'b0),
      .key_mask('0), .hit(pr_hits[g])
    );
    ptlb_cmp #(.VPN2_W(VPN2_W), .ASID_W(ASID_W), .MASK_W(MASK_W)) u_cf (
      .tag_vpn2(e_vpn2[g]), .tag_asid(e_asid[g]), .tag_global(e_global[g]), .tag_mask(e_mask[g]),
      .key_vpn2(wr_vpn2), .key_asid(wr_asid), .key_global(wr_global),
      .key_mask(wr_mask), .hit(cf_raw[g])
    );
    always_comb cf_hits[g] = cf_raw[g] && (e_lo0[g][0] || e_lo1[g][0]) &&
                             (wr_idx != IDX_W'(g));
  end

  logic             lk_found;
  logic [IDX_W-1:0] lk_idx;

  ptlb_first #(.IDX_W(IDX_W)) u_lk_first (.hits(lk_hits), .found(lk_found), .idx(lk_idx));
  ptlb_first #(.IDX_W(IDX_W)) u_pr_first (.hits(pr_hits), .found(pr_found), .idx(pr_idx));

  // Read port
  always_comb begin
    rd_vpn2   = e_vpn2[rd_idx];
    rd_asid   = e_asid[rd_idx];
    rd_global = e_global[rd_idx];
    rd_mask   = e_mask[rd_idx];
    rd_lo0    = e_lo0[rd_idx];
    rd_lo1    = e_lo1[rd_idx];
  end

  // Lookup next-state
  logic [MASK_W-1:0] hmask;
  logic [SEL_W-1:0]  sel_oh;
  logic              odd;
  logic [LO_W-1:0]   half;
  logic [PFN_W-1:0]  h_pfn;
  logic [2:0]        h_attr;
  logic              h_v, h_d, h_ri, h_xi, is_load;
  acc_e              acc;
  logic [PA_W-1:0]   omask, va_ofs, pfn_pa;
  fault_e            fault_d;
  logic [PA_W-1:0]   pa_d;
  logic [2:0]        attr_d;

  always_comb begin
    hmask   = e_mask[lk_idx];
    sel_oh  = {1'b0, hmask} + SEL_W'(1);
    odd     = |(lk_va[PG_OFS_W +: SEL_W] & sel_oh);
    half    = odd ? e_lo1[lk_idx] : e_lo0[lk_idx];
    h_v     = half[0];
    h_d     = half[1];
    h_attr  = half[4:2];
    h_pfn   = half[PFN_W+4:5];
    h_xi    = half[PFN_W+5];
    h_ri    = half[PFN_W+6];
    acc     = acc_e'(lk_acc);
    is_load = (acc == ACC_LOAD) || (acc == ACC_LOAD_ALT);

    omask                 = '0;
    omask[OFS_MAX-1:0]    = {hmask, {PG_OFS_W{1'b1}}};
    va_ofs                = '0;
    va_ofs[OFS_MAX-1:0]   = lk_va[OFS_MAX-1:0];
    pfn_pa                = {h_pfn, {PG_OFS_W{1'b0}}};

    if (!lk_found)                        fault_d = FLT_MISS;
    else if (!h_v)                        fault_d = FLT_INVALID;
    else if (is_load && h_ri)             fault_d = FLT_RD_INH;
    else if ((acc == ACC_FETCH) && h_xi)  fault_d = FLT_EX_INH;
    else if ((acc == ACC_STORE) && !h_d)  fault_d = FLT_MODIFIED;
    else                                  fault_d = FLT_NONE;

    if (fault_d == FLT_NONE) begin
      pa_d   = (pfn_pa & ~omask) | (va_ofs & omask);
      attr_d = h_attr;
    end else begin
      pa_d   = '0;
      attr_d = '0;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      wr_conflict <= 1'b0;
    end else begin
      res_valid   <= lk_valid;
      wr_conflict <= wr_en && (|cf_hits);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_pa    <= '0;
      res_cattr <= '0;
      res_fault <= '0;
    end else if (lk_valid) begin
      res_pa    <= pa_d;
      res_cattr <= attr_d;
      res_fault <= fault_d;
    end
  end
endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int IDX_W  = 4,
  parameter int PA_W   = 32,
  parameter int VPN2_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              res_valid,
  input logic [PA_W-1:0]   res_pa,
  input logic [2:0]        res_cattr,
  input logic [2:0]        res_fault,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [VPN2_W-1:0] wr_vpn2,
  input logic              wr_conflict,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [VPN2_W-1:0] rd_vpn2,
  input logic              pr_found,
  input logic [IDX_W-1:0]  pr_idx
);
  // R3
  res_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);

  // R3
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);

  // R3
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(res_fault) && $stable(res_pa)));

  // R10
  fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault <= 3'd5));

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault != 3'd0) |-> (res_pa == '0 && res_cattr == 3'd0));

  // R12
  probe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_found |-> (pr_idx == '0));

  // R13
  conflict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_conflict |-> $past(wr_en));

  // R2
  write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_idx != $past(wr_idx)) || (rd_vpn2 == $past(wr_vpn2))));
endmodule

bind pair_tlb ptlb_chk #(.IDX_W(IDX_W), .PA_W(PA_W), .VPN2_W(VPN2_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_pa(res_pa), .res_cattr(res_cattr), .res_fault(res_fault),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_conflict(wr_conflict),
  .rd_idx(rd_idx), .rd_vpn2(rd_vpn2), .pr_found(pr_found), .pr_idx(pr_idx)
);

// File: tb/test_pair_tlb.sv
`timescale 1ns/1ps
module test_pair_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic [1:0]  lk_acc;
  logic        res_valid;
  logic [31:0] res_pa;
  logic [2:0]  res_cattr, res_fault;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [18:0] wr_vpn2;
  logic [7:0]  wr_asid;
  logic        wr_global;
  logic [15:0] wr_mask;
  logic [26:0] wr_lo0, wr_lo1;
  logic        wr_conflict;
  logic [3:0]  rd_idx;
  logic [18:0] rd_vpn2;
  logic [7:0]  rd_asid;
  logic        rd_global;
  logic [15:0] rd_mask;
  logic [26:0] rd_lo0, rd_lo1;
  logic [18:0] pr_vpn2;
  logic [7:0]  pr_asid;
  logic        pr_found;
  logic [3:0]  pr_idx;

  always #2.5 clk = ~clk;

  pair_tlb i_pair_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .res_valid(res_valid), .res_pa(res_pa), .res_cattr(res_cattr),
    .res_fault(res_fault), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_mask(wr_mask), .wr_lo0(wr_lo0),
    .wr_lo1(wr_lo1), .wr_conflict(wr_conflict), .rd_idx(rd_idx), .rd_vpn2(rd_vpn2),
    .rd_asid(rd_asid), .rd_global(rd_global), .rd_mask(rd_mask), .rd_lo0(rd_lo0),
    .rd_lo1(rd_lo1), .pr_vpn2(pr_vpn2), .pr_asid(pr_asid), .pr_found(pr_found),
    .pr_idx(pr_idx)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural model state
  logic [18:0] m_vpn2 [N];
  logic [7:0]  m_asid [N];
  logic        m_g    [N];
  logic [15:0] m_mask [N];
  logic [26:0] m_lo0  [N];
  logic [26:0] m_lo1  [N];
  logic        x_valid;
  logic [31:0] x_pa;
  logic [2:0]  x_attr, x_fault;
  logic        x_conf;

  function automatic logic [26:0] mk(input logic ri, input logic xi, input logic [19:0] pfn,
                                     input logic [2:0] at, input logic d, input logic v);
    return {ri, xi, pfn, at, d, v};
  endfunction

  function automatic bit tag_match(input int i, input logic [18:0] key, input logic [7:0] as);
    logic [18:0] care;
    care = ~{3'b000, m_mask[i]};
    return (((key ^ m_vpn2[i]) & care) == 19'd0) && (m_g[i] || as == m_asid[i]);
  endfunction

  task automatic mlook(input logic [31:0] va, input logic [7:0] as, input logic [1:0] acc,
                       output logic [2:0] f, output logic [31:0] pa, output logic [2:0] at);
    int hit;
    int k;
    logic [26:0] lo;
    logic [31:0] om;
    hit = -1;
    f = 3'd0; pa = 32'd0; at = 3'd0;
    for (int i = 0; i < N; i++) if (hit < 0 && tag_match(i, va[31:13], as)) hit = i;
    if (hit < 0) f = 3'd1;
    else begin
      k = 0;
      for (int b = 0; b < 16; b++) if (m_mask[hit][b]) k++;
      lo = va[12 + k] ? m_lo1[hit] : m_lo0[hit];
      if (!lo[0]) f = 3'd2;
      else if ((acc == 2'd0 || acc == 2'd3) && lo[26]) f = 3'd3;
      else if (acc == 2'd2 && lo[25]) f = 3'd4;
      else if (acc == 2'd1 && !lo[1]) f = 3'd5;
      else begin
        om = ({16'd0, m_mask[hit]} << 12) | 32'hfff;
        pa = ({lo[24:5], 12'd0} & ~om) | (va & om);
        at = lo[4:2];
      end
    end
  endtask

  function automatic bit mconf();
    logic [18:0] care;
    for (int i = 0; i < N; i++) begin
      care = ~{3'b000, (m_mask[i] | wr_mask)};
      if (i != int'(wr_idx) && (m_lo0[i][0] || m_lo1[i][0]) &&
          (((wr_vpn2 ^ m_vpn2[i]) & care) == 19'd0) &&
          (m_g[i] || wr_global || m_asid[i] == wr_asid)) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_vpn2[i] = '0; m_asid[i] = '0; m_g[i] = 1'b0;
        m_mask[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
      end
      x_valid = 1'b0; x_pa = '0; x_attr = '0; x_fault = '0; x_conf = 1'b0;
    end else begin
      if (lk_valid) mlook(lk_va, lk_asid, lk_acc, x_fault, x_pa, x_attr);
      x_valid = lk_valid;
      x_conf  = wr_en && mconf();
      if (wr_en) begin
        m_vpn2[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid; m_g[wr_idx] = wr_global;
        m_mask[wr_idx] = wr_mask; m_lo0[wr_idx] = wr_lo0; m_lo1[wr_idx] = wr_lo1;
      end
    end
  end

  function automatic string fault_req(input logic [2:0] f);
    case (f)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3, 3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic comb_checks();
    int pi;
    pi = -1;
    for (int i = 0; i < N; i++) if (pi < 0 && tag_match(i, pr_vpn2, pr_asid)) pi = i;
    chk("R12", "probe found", pr_found, (pi >= 0));
    chk("R12", "probe index", pr_idx, (pi >= 0) ? pi : 0);
    chk("R2", "read tag", rd_vpn2, m_vpn2[rd_idx]);
    chk("R2", "read asid", rd_asid, m_asid[rd_idx]);
    chk("R2", "read global", rd_global, m_g[rd_idx]);
    chk("R2", "read mask", rd_mask, m_mask[rd_idx]);
    chk("R2", "read lo0", rd_lo0, m_lo0[rd_idx]);
    chk("R2", "read lo1", rd_lo1, m_lo1[rd_idx]);
  endtask

  task automatic reg_checks();
    chk("R3", "res_valid", res_valid, x_valid);
    if (x_valid) begin
      chk(fault_req(x_fault), "fault", res_fault, x_fault);
      chk(fault_req(x_fault), "pa", res_pa, x_pa);
      chk(fault_req(x_fault), "attr", res_cattr, x_attr);
    end
    chk("R13", "conflict", wr_conflict, x_conf);
  endtask

  task automatic step();
    #1;
    comb_checks();
    @(negedge clk);
    reg_checks();
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [18:0] vpn2, input logic [7:0] as,
                          input logic g, input logic [15:0] mask,
                          input logic [26:0] lo0, input logic [26:0] lo1);
    wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_asid = as; wr_global = g;
    wr_mask = mask; wr_lo0 = lo0; wr_lo1 = lo1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_look(input logic [31:0] va, input logic [7:0] as, input logic [1:0] acc);
    lk_valid = 1'b1; lk_va = va; lk_asid = as; lk_acc = acc;
    step();
    lk_valid = 1'b0;
  endtask

  task automatic check_res(input string req, input logic [2:0] f,
                           input logic [31:0] pa, input logic [2:0] at);
    chk(req, "res_valid", res_valid, 1'b1);
    chk(req, "fault", res_fault, f);
    chk(req, "pa", res_pa, pa);
    chk(req, "attr", res_cattr, at);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_acc = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn2 = '0; wr_asid = '0; wr_global = 1'b0;
    wr_mask = '0; wr_lo0 = '0; wr_lo1 = '0; rd_idx = '0; pr_vpn2 = 19'h7ffff; pr_asid = 8'hff;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "res_valid", res_valid, 1'b0);
    chk("R1", "conflict", wr_conflict, 1'b0);
    for (int i = 0; i < N; i++) begin
      rd_idx = 4'(i);
      #0.1;
      chk("R1", "entry words", {rd_vpn2, rd_asid, rd_global, rd_mask}, 64'd0);
      chk("R1", "entry halves", {rd_lo0, rd_lo1}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write and read back
    do_write(4'd3, 19'h12, 8'd5, 1'b0, 16'h0,
             mk(0, 0, 20'h00111, 3'd3, 1, 1), mk(0, 0, 20'h00222, 3'd2, 0, 1));
    rd_idx = 4'd3;
    #1;
    chk("R2", "written tag", rd_vpn2, 19'h12);
    chk("R2", "written lo1", rd_lo1, mk(0, 0, 20'h00222, 3'd2, 0, 1));

    // R5: even and odd halves
    do_look({19'h12, 1'b0, 12'habc}, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h00111abc, 3'd3);
    do_look({19'h12, 1'b1, 12'h123}, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h00222123, 3'd2);
    // R9: store to clean half
    do_look({19'h12, 1'b1, 12'h123}, 8'd5, 2'd1);
    check_res("R9", 3'd5, 32'h0, 3'd0);

    // R4 / R6: identifier mismatch misses, global entry matches any identifier
    do_look({19'h12, 1'b0, 12'h000}, 8'd6, 2'd0);
    check_res("R4", 3'd1, 32'h0, 3'd0);
    do_write(4'd4, 19'h40, 8'h77, 1'b1, 16'h0,
             mk(0, 0, 20'h00333, 3'd1, 1, 1), mk(0, 0, 20'h00334, 3'd1, 1, 1));
    do_look({19'h40, 1'b0, 12'h010}, 8'd5, 2'd2);
    check_res("R4", 3'd0, 32'h00333010, 3'd1);
    do_look({19'h41, 1'b0, 12'h010}, 8'd5, 2'd0);
    check_res("R6", 3'd1, 32'h0, 3'd0);

    // R7 / R8 / R10: flags and priority
    do_write(4'd5, 19'h50, 8'd5, 1'b0, 16'h0,
             mk(1, 1, 20'h00444, 3'd0, 0, 0), mk(1, 1, 20'h00555, 3'd0, 0, 1));
    do_look({19'h50, 1'b0, 12'h0}, 8'd5, 2'd2);
    check_res("R10", 3'd2, 32'h0, 3'd0);
    do_look({19'h50, 1'b0, 12'h0}, 8'd5, 2'd1);
    check_res("R7", 3'd2, 32'h0, 3'd0);
    do_look({19'h50, 1'b1, 12'h0}, 8'd5, 2'd0);
    check_res("R8", 3'd3, 32'h0, 3'd0);
    do_look({19'h50, 1'b1, 12'h0}, 8'd5, 2'd2);
    check_res("R8", 3'd4, 32'h0, 3'd0);
    do_look({19'h50, 1'b1, 12'h0}, 8'd5, 2'd1);
    check_res("R10", 3'd5, 32'h0, 3'd0);

    // R5: 256 MB pages and 64 KB pages
    do_write(4'd6, 19'h20000, 8'd5, 1'b0, 16'hffff,
             mk(0, 0, 20'h30000, 3'd4, 1, 1), mk(0, 0, 20'h50000, 3'd4, 1, 1));
    do_look(32'h4abcdef0, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h3abcdef0, 3'd4);
    do_look(32'h51234567, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h51234567, 3'd4);
    do_write(4'd8, 19'h130, 8'd5, 1'b0, 16'h000f,
             mk(0, 0, 20'h00a00, 3'd5, 1, 1), mk(0, 0, 20'h00b00, 3'd5, 1, 1));
    do_look(32'h00261234, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h00a01234, 3'd5);
    do_look(32'h00275678, 8'd5, 2'd0);
    check_res("R5", 3'd0, 32'h00b05678, 3'd5);

    // R11 / R13 / R12: overlapping entries
    do_write(4'd9, 19'h60, 8'd5, 1'b0, 16'h0,
             mk(0, 0, 20'h00999, 3'd6, 1, 1), mk(0, 0, 20'h0099a, 3'd6, 1, 1));
    chk("R13", "no overlap", wr_conflict, 1'b0);
    do_write(4'd7, 19'h60, 8'd5, 1'b0, 16'h0,
             mk(0, 0, 20'h00777, 3'd7, 1, 1), mk(0, 0, 20'h00778, 3'd7, 1, 1));
    chk("R13", "overlap flagged", wr_conflict, 1'b1);
    do_look({19'h60, 1'b0, 12'h004}, 8'd5, 2'd0);
    check_res("R11", 3'd0, 32'h00777004, 3'd7);
    pr_vpn2 = 19'h60; pr_asid = 8'd5;
    #1;
    chk("R12", "probe hit", {pr_found, pr_idx}, {1'b1, 4'd7});
    pr_vpn2 = 19'h61;
    #1;
    chk("R12", "probe miss", {pr_found, pr_idx}, {1'b0, 4'd0});
    // R13: rewriting an entry with itself is no overlap
    do_write(4'd3, 19'h12, 8'd5, 1'b0, 16'h0,
             mk(0, 0, 20'h00111, 3'd3, 1, 1), mk(0, 0, 20'h00222, 3'd2, 0, 1));
    chk("R13", "self rewrite", wr_conflict, 1'b0);

    // R3: same-cycle write unseen, hold when idle
    wr_en = 1'b1; wr_idx = 4'd10; wr_vpn2 = 19'h70; wr_asid = 8'd5; wr_global = 1'b0;
    wr_mask = 16'h0; wr_lo0 = mk(0, 0, 20'h00aaa, 3'd1, 1, 1); wr_lo1 = wr_lo0;
    lk_valid = 1'b1; lk_va = {19'h70, 1'b0, 12'h0}; lk_asid = 8'd5; lk_acc = 2'd0;
    step();
    wr_en = 1'b0; lk_valid = 1'b0;
    check_res("R3", 3'd1, 32'h0, 3'd0);
    do_look({19'h70, 1'b0, 12'h0}, 8'd5, 2'd0);
    check_res("R3", 3'd0, 32'h00aaa000, 3'd1);
    step();
    chk("R3", "idle res_valid", res_valid, 1'b0);
    chk("R3", "held pa", res_pa, 32'h00aaa000);

    // Random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      logic [15:0] mk_sel;
      case ($urandom % 4)
        0: mk_sel = 16'h0;
        1: mk_sel = 16'h1;
        2: mk_sel = 16'h3;
        default: mk_sel = 16'hf;
      endcase
      wr_en     = ($urandom % 6) == 0;
      wr_idx    = 4'($urandom);
      wr_vpn2   = 19'($urandom % 24);
      wr_asid   = 8'($urandom % 3);
      wr_global = ($urandom % 5) == 0;
      wr_mask   = mk_sel;
      wr_lo0    = 27'($urandom);
      wr_lo1    = 27'($urandom);
      lk_valid  = ($urandom % 4) != 0;
      lk_va     = {19'($urandom % 24), 13'($urandom)};
      lk_asid   = 8'($urandom % 3);
      lk_acc    = 2'($urandom);
      pr_vpn2   = 19'($urandom % 24);
      pr_asid   = 8'($urandom % 3);
      rd_idx    = 4'($urandom);
      step();
    end
    wr_en = 1'b0; lk_valid = 1'b0;
    step();

    finished = 1;
    summary();
    $finish;
  end
endmodule